// File: doc/BRIEF.md
# Character LCD Parallel Bus Master

This block sits on the host side of a character LCD module. It performs one register access per request over the module's strobe-based parallel bus, which has a register-select line, a read/write line, an enable strobe and eight data lines. A request carries the register select, the direction, a write byte and a flag that chooses 8-bit or 4-bit bus width. The block accepts the request when it is idle. It then sequences the enable strobe and drives or releases the data lines. When the last enable cycle ends, it raises a one-cycle done pulse and presents the read byte with that pulse.

All bus phases are timed by counting system clock cycles. Each count is derived from a nanosecond minimum and the clock period parameter. A fixed allowance for enable edge transition time is added to every minimum, and the result is rounded up. In 4-bit mode only the upper four data lines carry data. Each byte then becomes two full enable cycles: the upper nibble goes first, then the lower nibble.

Top module: `lcd_bus_master`

## Requirements
- R1: After reset, and after a reset applied in mid-transaction, `lcd_e` and `lcd_db_oe` are low, `req_ready` is high and `rsp_done` is low.
- R2: After a request is accepted, `lcd_rs` and `lcd_rw` are driven to the request's values. The enable line then stays low for exactly N_SU = ceil((140 + 25) ns / clock period) cycles before it rises.
- R3: Each enable high pulse lasts exactly N_PW clock cycles. N_PW is ceil((max(450, 195, 320) + 25) ns / clock period).
- R4: After each falling edge of the enable line, it stays low for N_LOW cycles before the done pulse or the next setup phase. N_LOW is the larger of ceil((20 + 25) ns / period) and N_CYC − N_PW, where N_CYC = ceil((1000 + 25) ns / period). As a result, N_PW + N_LOW ≥ N_CYC.
- R5: `lcd_rs` and `lcd_rw` do not change while the enable line is high.
- R6: In 8-bit mode, a write (`req_rd`=0) drives `req_wdata` onto `lcd_db_out[7:0]`, with `lcd_db_oe` high and the data stable throughout the enable pulse.
- R7: In 4-bit mode (`req_nibble`=1), a transaction uses exactly two enable pulses. On a write, `lcd_db_out[7:4]` carries bits 7:4 of the byte during the first pulse and bits 3:0 during the second, and `lcd_db_out[3:0]` is zero. In 8-bit mode, a transaction uses exactly one pulse.
- R8: On a read, `lcd_db_oe` stays low for the whole transaction. `lcd_db_in` is sampled in the last cycle of each enable pulse. In 4-bit mode, only `lcd_db_in[7:4]` is used: the first pulse gives read bits 7:4 and the second gives bits 3:0.
- R9: `rsp_done` is high for exactly one cycle, in the last low cycle of the final enable cycle, and `rsp_rdata` holds the read byte in that cycle. While a transaction runs, `req_ready` is low and a raised `req_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a valid request is taken this cycle |
| req_rs | input | 1 | Register select value for the access |
| req_rd | input | 1 | 1 = read access, 0 = write access |
| req_wdata | input | 8 | Byte to write |
| req_nibble | input | 1 | 1 = 4-bit bus mode, 0 = 8-bit bus mode |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Byte read; valid with `rsp_done` |
| lcd_rs | output | 1 | Register select line to the module |
| lcd_rw | output | 1 | Read/write line to the module (1 = read) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db_out | output | 8 | Data lines, outbound value |
| lcd_db_oe | output | 1 | Data line output enable |
| lcd_db_in | input | 8 | Data lines, inbound value |

## Verification
The bench builds the block with its default parameters: a 4000 ps clock period and the nominal nanosecond minima. This gives N_SU = 42, N_PW = 119, N_CYC = 257 and N_LOW = 138. With these values, the cycle-time term rather than the hold term sets the low phase, so R4's larger-of rule is exercised on its non-trivial branch. The phases are long enough that each pulse width and setup run can be counted exactly at the ports. Garbage placed on the unused lower data lines in 4-bit reads shows that those lines are ignored.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_HIGH  = 2'd2,
    PH_LOW   = 2'd3
  } lcd_phase_e;

  // Minimum time plus edge allowance, expressed in whole clock cycles (rounded up).
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned margin_ns,
                                               input int unsigned period_ps);
    int unsigned total_ps;
    total_ps = (t_ns + margin_ns) * 1000;
    return (total_ps + period_ps - 1) / period_ps;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Low phase: covers hold times and tops the enable cycle up to its minimum.
  function automatic int unsigned low_cycles(input int unsigned n_hold,
                                             input int unsigned n_cyc,
                                             input int unsigned n_pw);
    int unsigned rest;
    rest = (n_cyc > n_pw) ? (n_cyc - n_pw) : 1;
    return max_u(max_u(n_hold, rest), 1);
  endfunction

endpackage

// File: rtl/lcd_phase_timer.sv
module lcd_phase_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expire = (cnt_q == '0);

  // R10-style guard: a running phase always counts down by exactly one.
  assert_timer_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !expire) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/lcd_bus_fsm.sv
module lcd_bus_fsm
  import lcd_bus_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned N_SU  = 42,
  parameter int unsigned N_PW  = 119,
  parameter int unsigned N_LOW = 138
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_nibble,
  input  logic             expire,
  output lcd_phase_e       phase,
  output logic             load,
  output logic [CNT_W-1:0] load_val,
  output logic             accept,
  output logic             capture,
  output logic             second_nib,
  output logic             nib_mode,
  output logic             done
);

  localparam logic [CNT_W-1:0] LD_SU  = CNT_W'(N_SU - 1);
  localparam logic [CNT_W-1:0] LD_PW  = CNT_W'(N_PW - 1);
  localparam logic [CNT_W-1:0] LD_LOW = CNT_W'(N_LOW - 1);

  lcd_phase_e phase_q, phase_d;
  logic       nib_q, mode_q;
  logic       more_nib;

  assign more_nib = mode_q && !nib_q;
  assign accept   = (phase_q == PH_IDLE) && req_valid;
  assign capture  = (phase_q == PH_HIGH) && expire;

  always_comb begin
    phase_d  = phase_q;
    load     = 1'b0;
    load_val = '0;
    done     = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_d  = PH_SETUP;
          load     = 1'b1;
          load_val = LD_SU;
        end
      end
      PH_SETUP: begin
        if (expire) begin
          phase_d  = PH_HIGH;
          load     = 1'b1;
          load_val = LD_PW;
        end
      end
      PH_HIGH: begin
        if (expire) begin
          phase_d  = PH_LOW;
          load     = 1'b1;
          load_val = LD_LOW;
        end
      end
      PH_LOW: begin
        if (expire) begin
          if (more_nib) begin
            phase_d  = PH_SETUP;
            load     = 1'b1;
            load_val = LD_SU;
          end else begin
            phase_d = PH_IDLE;
            done    = 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      nib_q   <= 1'b0;
      mode_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        nib_q  <= 1'b0;
        mode_q <= req_nibble;
      end else if ((phase_q == PH_LOW) && expire && more_nib) begin
        nib_q <= 1'b1;
      end
    end
  end

  assign phase      = phase_q;
  assign second_nib = nib_q;
  assign nib_mode   = mode_q;

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> !(accept && $past(phase_q == PH_HIGH)));

endmodule

// File: rtl/lcd_data_path.sv
module lcd_data_path (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       active,
  input  logic       capture,
  input  logic       second_nib,
  input  logic       nib_mode,
  input  logic       req_rs,
  input  logic       req_rd,
  input  logic [7:0] req_wdata,
  input  logic [7:0] db_in,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic [7:0] db_out,
  output logic       db_oe,
  output logic [7:0] rdata
);

  logic       rs_q, rw_q;
  logic [7:0] wbyte_q, rbyte_q;
  logic [3:0] wnib;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q    <= 1'b0;
      rw_q    <= 1'b0;
      wbyte_q <= '0;
    end else if (accept) begin
      rs_q    <= req_rs;
      rw_q    <= req_rd;
      wbyte_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbyte_q <= '0;
    end else if (capture) begin
      if (!nib_mode)        rbyte_q      <= db_in;
      else if (!second_nib) rbyte_q[7:4] <= db_in[7:4];
      else                  rbyte_q[3:0] <= db_in[7:4];
    end
  end

  assign wnib   = second_nib ? wbyte_q[3:0] : wbyte_q[7:4];
  assign db_out = nib_mode ? {wnib, 4'b0000} : wbyte_q;
  assign db_oe  = active && !rw_q;
  assign lcd_rs = rs_q;
  assign lcd_rw = rw_q;
  assign rdata  = rbyte_q;

  assert_addr_frozen_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !accept) |=> (active -> ($stable(rs_q) && $stable(rw_q))));

endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
  import lcd_bus_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_PS    = 4000,
  parameter int unsigned T_ADDR_SETUP_NS  = 140,
  parameter int unsigned T_ADDR_HOLD_NS   = 10,
  parameter int unsigned T_PULSE_NS       = 450,
  parameter int unsigned T_CYCLE_NS       = 1000,
  parameter int unsigned T_WDATA_SETUP_NS = 195,
  parameter int unsigned T_WDATA_HOLD_NS  = 10,
  parameter int unsigned T_RDATA_DELAY_NS = 320,
  parameter int unsigned T_RDATA_HOLD_NS  = 20,
  parameter int unsigned EDGE_MARGIN_NS   = 25,
  parameter int unsigned CNT_W            = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_rs,
  input  logic       req_rd,
  input  logic [7:0] req_wdata,
  input  logic       req_nibble,
  output logic       rsp_done,
  output logic [7:0] rsp_rdata,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db_out,
  output logic       lcd_db_oe,
  input  logic [7:0] lcd_db_in
);

  localparam int unsigned N_SU  = ns_to_cycles(T_ADDR_SETUP_NS, EDGE_MARGIN_NS, CLK_PERIOD_PS);
  localparam int unsigned PW_NS = max_u(T_PULSE_NS, max_u(T_WDATA_SETUP_NS, T_RDATA_DELAY_NS));
  localparam int unsigned N_PW  = ns_to_cycles(PW_NS, EDGE_MARGIN_NS, CLK_PERIOD_PS);
  localparam int unsigned N_CYC = ns_to_cycles(T_CYCLE_NS, EDGE_MARGIN_NS, CLK_PERIOD_PS);
  localparam int unsigned HD_NS = max_u(T_ADDR_HOLD_NS, max_u(T_WDATA_HOLD_NS, T_RDATA_HOLD_NS));
  localparam int unsigned N_HD  = ns_to_cycles(HD_NS, EDGE_MARGIN_NS, CLK_PERIOD_PS);
  localparam int unsigned N_LOW = low_cycles(N_HD, N_CYC, N_PW);

  lcd_phase_e       phase;
  logic             load, expire, accept, capture, second_nib, nib_mode, done;
  logic [CNT_W-1:0] load_val;
  logic             active;

  lcd_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .expire   (expire)
  );

  lcd_bus_fsm #(
    .CNT_W (CNT_W),
    .N_SU  (N_SU),
    .N_PW  (N_PW),
    .N_LOW (N_LOW)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_nibble (req_nibble),
    .expire     (expire),
    .phase      (phase),
    .load       (load),
    .load_val   (load_val),
    .accept     (accept),
    .capture    (capture),
    .second_nib (second_nib),
    .nib_mode   (nib_mode),
    .done       (done)
  );

  assign active = (phase != PH_IDLE);

  lcd_data_path data_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .active     (active),
    .capture    (capture),
    .second_nib (second_nib),
    .nib_mode   (nib_mode),
    .req_rs     (req_rs),
    .req_rd     (req_rd),
    .req_wdata  (req_wdata),
    .db_in      (lcd_db_in),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .db_out     (lcd_db_out),
    .db_oe      (lcd_db_oe),
    .rdata      (rsp_rdata)
  );

  assign lcd_e     = (phase == PH_HIGH);
  assign req_ready = !active;
  assign rsp_done  = done;

  // Run-length counters observed by the assertions below.
  logic [CNT_W-1:0] hi_run_q, lo_run_q, since_rise_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run_q     <= '0;
      lo_run_q     <= '0;
      since_rise_q <= '0;
    end else begin
      hi_run_q     <= lcd_e ? hi_run_q + 1'b1 : '0;
      lo_run_q     <= (active && !lcd_e) ? lo_run_q + 1'b1 : '0;
      since_rise_q <= (lcd_e && !hi_run_q[0] && hi_run_q == '0) ? 1 : since_rise_q + 1'b1;
    end
  end

  assert_setup_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_e) |-> (lo_run_q >= CNT_W'(N_SU)));

  assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_e) |-> (hi_run_q == CNT_W'(N_PW)));

  assert_cycle_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (since_rise_q >= CNT_W'(N_CYC - 1)));

  assert_rs_rw_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e)) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

  assert_wdata_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && $past(lcd_e) && lcd_db_oe) |-> $stable(lcd_db_out));

  assert_read_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lcd_e && lcd_rw) |-> !lcd_db_oe);

endmodule

// File: tb/lcd_bus_master_tb_top.sv
module lcd_bus_master_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_rs = 1'b0;
  logic       req_rd = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       req_nibble = 1'b0;
  logic       rsp_done;
  logic [7:0] rsp_rdata;
  logic       lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [7:0] lcd_db_out;
  logic [7:0] lcd_db_in = 8'h00;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  lcd_bus_master dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_rs     (req_rs),
    .req_rd     (req_rd),
    .req_wdata  (req_wdata),
    .req_nibble (req_nibble),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata),
    .lcd_rs     (lcd_rs),
    .lcd_rw     (lcd_rw),
    .lcd_e      (lcd_e),
    .lcd_db_out (lcd_db_out),
    .lcd_db_oe  (lcd_db_oe),
    .lcd_db_in  (lcd_db_in)
  );

  // Expected phase lengths, restated from the requirements with real arithmetic.
  function automatic int cyc_of(input int ns);
    return int'($ceil((real'(ns) + 25.0) / 4.0));
  endfunction

  localparam int E_SU  = 42;
  localparam int E_PW  = 119;
  localparam int E_CYC = 257;
  localparam int E_LOW = 138;

  // {rs, rd, nibble, wdata[7:0], read byte[7:0]}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5, 8'h00},
    {1'b1, 1'b0, 1'b0, 8'h3C, 8'h00},
    {1'b1, 1'b1, 1'b0, 8'h00, 8'h96},
    {1'b0, 1'b0, 1'b1, 8'h7E, 8'h00},
    {1'b1, 1'b1, 1'b1, 8'h00, 8'hC3},
    {1'b0, 1'b1, 1'b1, 8'h00, 8'h5A}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Issue one access and observe it at the pins, one sample per negedge.
  task automatic run_txn(input logic rs, input logic rd, input logic nib,
                         input logic [7:0] wd, input logic [7:0] rb);
    int         pulses = 0, first_lo = -1, lo = 0, hi = 0, lo_at_done = -1;
    int         w0 = -1, w1 = -1, gap = -1, oe_bad = 0, rsrw_bad = 0, done_n = 0;
    logic [7:0] out0 = 8'h00, out1 = 8'h00, got_rd = 8'h00;
    logic       pe = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", int'(req_ready), 1);
    req_rs = rs; req_rd = rd; req_wdata = wd; req_nibble = nib; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int n = 0; n < 4000; n++) begin
      if (lcd_e && !pe) begin
        pulses++;
        if (pulses == 1) first_lo = lo; else gap = lo;
        hi = 0;
        if (nib) lcd_db_in = (pulses == 1) ? {rb[7:4], 4'hA} : {rb[3:0], 4'h5};
        else     lcd_db_in = rb;
      end
      if (lcd_e) begin
        hi++;
        if (lcd_rs !== rs || lcd_rw !== rd) rsrw_bad++;
        if (rd && lcd_db_oe) oe_bad++;
        if (!rd && !lcd_db_oe) oe_bad++;
        if (pulses == 1) out0 = lcd_db_out; else out1 = lcd_db_out;
      end else begin
        if (rd && lcd_db_oe) oe_bad++;
        if (pe) begin
          if (pulses == 1) w0 = hi; else w1 = hi;
          lo = 0;
        end
        lo++;
      end
      if (rsp_done) begin
        done_n++;
        lo_at_done = lo;
        got_rd = rsp_rdata;
        break;
      end
      pe = lcd_e;
      @(negedge clk);
    end
    chk(done_n == 1, "R9", "done seen", done_n, 1);
    chk(pulses == (nib ? 2 : 1), "R7", "enable pulse count", pulses, nib ? 2 : 1);
    chk(first_lo == E_SU, "R2", "setup cycles before first rise", first_lo, E_SU);
    chk(w0 == E_PW, "R3", "first pulse width", w0, E_PW);
    if (nib) begin
      chk(w1 == E_PW, "R3", "second pulse width", w1, E_PW);
      chk(gap == E_LOW + E_SU, "R4", "low gap between nibbles", gap, E_LOW + E_SU);
    end
    chk(lo_at_done == E_LOW, "R4", "low cycles to done", lo_at_done, E_LOW);
    chk(E_PW + E_LOW >= E_CYC, "R4", "cycle minimum", E_PW + E_LOW, E_CYC);
    chk(rsrw_bad == 0, "R5", "rs/rw wrong during pulse", rsrw_bad, 0);
    if (rd) begin
      chk(oe_bad == 0, "R8", "oe asserted during read", oe_bad, 0);
      chk(got_rd == rb, "R8", "read byte", got_rd, rb);
    end else if (nib) begin
      chk(oe_bad == 0, "R7", "oe low during write pulse", oe_bad, 0);
      chk({out0[7:4], out1[7:4]} == wd, "R7", "nibble order", {out0[7:4], out1[7:4]}, wd);
      chk(out0[3:0] == 4'h0 && out1[3:0] == 4'h0, "R7", "unused lines zero",
          {out0[3:0], out1[3:0]}, 0);
    end else begin
      chk(oe_bad == 0, "R6", "oe low during write pulse", oe_bad, 0);
      chk(out0 == wd, "R6", "write byte", out0, wd);
    end
    @(negedge clk);
    chk(rsp_done == 1'b0 && req_ready == 1'b1, "R9", "done single cycle then idle",
        {rsp_done, req_ready}, 2'b01);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int rises;
    chk(cyc_of(140) == E_SU && cyc_of(475 - 25) == E_PW && cyc_of(1000) == E_CYC,
        "R3", "bench phase table", cyc_of(140), E_SU);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(lcd_e == 1'b0 && lcd_db_oe == 1'b0 && req_ready == 1'b1 && rsp_done == 1'b0,
        "R1", "reset outputs", {lcd_e, lcd_db_oe, req_ready, rsp_done}, 4'b0010);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_txn(VEC[v][18], VEC[v][17], VEC[v][16], VEC[v][15:8], VEC[v][7:0]);
    end

    // R9: a request raised while busy is ignored
    @(negedge clk);
    req_rs = 1'b0; req_rd = 1'b0; req_nibble = 1'b0; req_wdata = 8'h11; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk(req_ready == 1'b0, "R9", "ready low while busy", int'(req_ready), 0);
    req_wdata = 8'hEE; req_valid = 1'b1;
    repeat (20) @(negedge clk);
    req_valid = 1'b0;
    while (!lcd_e) @(negedge clk);
    chk(lcd_db_out == 8'h11, "R9", "busy request did not replace data", lcd_db_out, 8'h11);
    while (!rsp_done) @(negedge clk);
    rises = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (lcd_e) rises++;
    end
    chk(rises == 0, "R9", "no extra transaction after busy request", rises, 0);

    // R1: reset in the middle of a pulse
    req_rd = 1'b0; req_wdata = 8'h42; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!lcd_e) @(negedge clk);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(lcd_e == 1'b0 && lcd_db_oe == 1'b0 && req_ready == 1'b1,
        "R1", "mid-transaction reset", {lcd_e, lcd_db_oe, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    run_txn(1'b1, 1'b0, 1'b1, 8'h9D, 8'h00);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule